// File: doc/BRIEF.md
# World-ID Bus Access Checker

This block is a firewall placed in front of one memory-mapped target. Every read or write request carries a 5-bit world ID that names the context it came from. The block holds a small set of programmable rule slots. Each slot gives a 64-bit base, a 64-bit byte size, a 64-bit map with one read grant and one write grant per world, and a five-bit control field. For each request the block works out whether it is allowed. An allowed request is passed on to the target. A blocked request never reaches the target, and it can be reported as an error response, an interrupt, or both.

Software sets up the slots through a separate register port. Only requests tagged with the trusted world ID, fixed at elaboration, may write that port. The first violation is recorded in status registers so that software can find out where it happened.

Top module: `wid_access_checker`

## Requirements
- R1: After reset, no response and no target request is issued and `irq_o` is low. Every slot resets to zero size, so every data access is denied.
- R2: A slot covers the addresses `base <= addr < base + size` over the full 64-bit address. A slot of size zero covers nothing.
- R3: For world w and direction d (0 = read, 1 = write), the grant is bit `2*w + d` of the 64-bit permission map. World w < 16 therefore lands in the low word and world w >= 16 in the high word at bit `2*(w-16) + d`.
- R4: An allowed request appears on the target port one clock after it is presented, with the same address, data and direction. Its response comes in that same cycle with no error. A read returns `tgt_rdata_i`.
- R5: A denied request is not forwarded, and its read data is zero. The response carries an error only when control bit 0 (for reads) or bit 1 (for writes) of the deciding slot is set. Otherwise it completes without an error.
- R6: A denied read sets the interrupt when control bit 2 of the deciding slot is set. A denied write does the same when control bit 3 is set. `irq_o` rises one clock after the request and stays high until it is cleared.
- R7: When slots overlap, the lowest-numbered slot that covers the address decides the outcome.
- R8: An address that no slot covers is denied with an error response, and it does not raise the interrupt.
- R9: The status registers capture the first violation after a clear: the address, the world and the direction. Later violations do not overwrite them. Writing 1 to bit 0 of the status word clears both the capture and the interrupt.
- R10: A register write whose world ID is not the trusted one is ignored and answered with an error. Register reads are allowed from any world.
- R11: Control bit 4 locks a slot. Any later write to a locked slot is ignored and answered with an error. Control bits 31:5 always read as zero.
- R12: Register words are addressed by word. Slot s occupies words `8s+0..8s+6`: base low, base high, size low, size high, permission low, permission high, control. Status sits at word `8*NUM_SLOTS` (bit 0 pending, bit 1 write, bits 12:8 world), followed by the fault address low and high words. The register response comes one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Data request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 64 | Request byte address |
| req_wdata_i | input | DATA_W | Write data |
| req_wid_i | input | 5 | World ID of the request |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_err_o | output | 1 | Error response |
| rsp_rdata_o | output | DATA_W | Read data, zero when blocked |
| tgt_valid_o | output | 1 | Forwarded request to the target |
| tgt_write_o | output | 1 | Forwarded direction |
| tgt_addr_o | output | 64 | Forwarded address |
| tgt_wdata_o | output | DATA_W | Forwarded write data |
| tgt_rdata_i | input | DATA_W | Target read data, valid while `tgt_valid_o` is high |
| cfg_valid_i | input | 1 | Register access present |
| cfg_write_i | input | 1 | Register write |
| cfg_addr_i | input | CFG_AW | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_wid_i | input | 5 | World ID of the register access |
| cfg_rsp_valid_o | output | 1 | Register response |
| cfg_rsp_err_o | output | 1 | Register access rejected |
| cfg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Latched violation interrupt |

## Verification
Wrong internal state shows at the ports within one clock. A wrong range compare, a wrong bit index in the permission map, or a wrong priority turns the forward and error pair of the very next response. A broken lock or trust check shows as an error flag on the register response, and readback then returns the changed value. A stale or overwritten capture, or an interrupt that is not cleared, shows on the next status read and on `irq_o`. The checks therefore target access on each side of the region edges, both map words, overlapping slots, and the readback that follows every rejected write.

// File: rtl/wac_pkg.sv
package wac_pkg;
  localparam int WID_W  = 5;
  localparam int AW     = 64;
  localparam int PERM_W = 2 ** (WID_W + 1);
  localparam int CTL_W  = 5;

  localparam int CTL_ERR_RD = 0;
  localparam int CTL_ERR_WR = 1;
  localparam int CTL_IRQ_RD = 2;
  localparam int CTL_IRQ_WR = 3;
  localparam int CTL_LOCK   = 4;

  typedef struct packed {
    logic [AW-1:0]     base;
    logic [AW-1:0]     size;
    logic [PERM_W-1:0] perm;
    logic [CTL_W-1:0]  ctl;
  } slot_t;
endpackage

// File: rtl/wac_decide.sv
module wac_decide
  import wac_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  slot_t [NUM_SLOTS-1:0] slots_i,
  input  logic                  valid_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [WID_W-1:0]      wid_i,
  input  logic                  write_i,
  output logic                  allow_o,
  output logic                  err_o,
  output logic                  irq_o
);
  logic [NUM_SLOTS-1:0] hit, grant;
  logic [WID_W:0]       pidx;

  assign pidx = {wid_i, write_i};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [AW-1:0] off;
    assign off      = addr_i - slots_i[s].base;
    assign hit[s]   = (addr_i >= slots_i[s].base) && (off < slots_i[s].size);
    assign grant[s] = slots_i[s].perm[pidx];
  end

  // lowest index assigned last, so it wins
  always_comb begin
    allow_o = 1'b0;
    err_o   = 1'b1;
    irq_o   = 1'b0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hit[s]) begin
        allow_o = grant[s];
        err_o   = !grant[s] && slots_i[s].ctl[write_i ? CTL_ERR_WR : CTL_ERR_RD];
        irq_o   = !grant[s] && slots_i[s].ctl[write_i ? CTL_IRQ_WR : CTL_IRQ_RD];
      end
    end
  end

  // R6
  deny_irq_chk: assert final (!(valid_i && irq_o && allow_o));
endmodule

// File: rtl/wac_regs.sv
module wac_regs
  import wac_pkg::*;
#(
  parameter int          NUM_SLOTS   = 4,
  parameter int          CFG_AW      = 8,
  parameter logic [4:0]  TRUSTED_WID = 5'd3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_valid_i,
  input  logic                  cfg_write_i,
  input  logic [CFG_AW-1:0]     cfg_addr_i,
  input  logic [31:0]           cfg_wdata_i,
  input  logic [WID_W-1:0]      cfg_wid_i,
  output logic                  cfg_rsp_valid_o,
  output logic                  cfg_rsp_err_o,
  output logic [31:0]           cfg_rdata_o,
  input  logic                  viol_i,
  input  logic                  viol_irq_i,
  input  logic                  viol_write_i,
  input  logic [AW-1:0]         viol_addr_i,
  input  logic [WID_W-1:0]      viol_wid_i,
  output slot_t [NUM_SLOTS-1:0] slots_o,
  output logic                  irq_o
);
  localparam int IDX_W = CFG_AW - 3;

  slot_t [NUM_SLOTS-1:0] slot_q;
  logic                  st_pend_q, st_write_q, irq_q;
  logic [WID_W-1:0]      st_wid_q;
  logic [AW-1:0]         st_addr_q;

  logic [IDX_W-1:0] idx;
  logic [2:0]       word;
  logic             is_slot, is_stat, trusted, locked, wr_ok, clr;
  logic [31:0]      rdata;

  assign idx     = cfg_addr_i[CFG_AW-1:3];
  assign word    = cfg_addr_i[2:0];
  assign is_slot = idx < IDX_W'(NUM_SLOTS);
  assign is_stat = idx == IDX_W'(NUM_SLOTS);
  assign trusted = cfg_wid_i == TRUSTED_WID;

  always_comb begin
    locked = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (idx == IDX_W'(s)) locked = slot_q[s].ctl[CTL_LOCK];
  end

  always_comb begin
    wr_ok = 1'b0;
    if (trusted) begin
      if (is_slot)      wr_ok = !locked && (word != 3'd7);
      else if (is_stat) wr_ok = word == 3'd0;
    end
  end

  assign clr = cfg_valid_i && cfg_write_i && wr_ok && is_stat && cfg_wdata_i[0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_store
    logic sel;
    assign sel = cfg_valid_i && cfg_write_i && wr_ok && is_slot && (idx == IDX_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[s] <= '0;
      else if (sel) begin
        case (word)
          3'd0: slot_q[s].base[31:0]  <= cfg_wdata_i;
          3'd1: slot_q[s].base[63:32] <= cfg_wdata_i;
          3'd2: slot_q[s].size[31:0]  <= cfg_wdata_i;
          3'd3: slot_q[s].size[63:32] <= cfg_wdata_i;
          3'd4: slot_q[s].perm[31:0]  <= cfg_wdata_i;
          3'd5: slot_q[s].perm[63:32] <= cfg_wdata_i;
          3'd6: slot_q[s].ctl         <= cfg_wdata_i[CTL_W-1:0];
          default: ;
        endcase
      end
    end

    // R11
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_q[s].ctl[CTL_LOCK] |=> $stable(slot_q[s]));
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (is_slot && idx == IDX_W'(s)) begin
        case (word)
          3'd0: rdata = slot_q[s].base[31:0];
          3'd1: rdata = slot_q[s].base[63:32];
          3'd2: rdata = slot_q[s].size[31:0];
          3'd3: rdata = slot_q[s].size[63:32];
          3'd4: rdata = slot_q[s].perm[31:0];
          3'd5: rdata = slot_q[s].perm[63:32];
          3'd6: rdata = {{(32-CTL_W){1'b0}}, slot_q[s].ctl};
          default: rdata = '0;
        endcase
      end
    end
    if (is_stat) begin
      case (word)
        3'd0: rdata = {19'd0, st_wid_q, 6'd0, st_write_q, st_pend_q};
        3'd1: rdata = st_addr_q[31:0];
        3'd2: rdata = st_addr_q[63:32];
        default: rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rsp_valid_o <= 1'b0;
      cfg_rsp_err_o   <= 1'b0;
      cfg_rdata_o     <= '0;
    end else begin
      cfg_rsp_valid_o <= cfg_valid_i;
      cfg_rsp_err_o   <= cfg_valid_i && cfg_write_i && !wr_ok;
      cfg_rdata_o     <= (cfg_valid_i && !cfg_write_i) ? rdata : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_pend_q  <= 1'b0;
      st_write_q <= 1'b0;
      st_wid_q   <= '0;
      st_addr_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (clr) begin
        st_pend_q  <= 1'b0;
        st_write_q <= 1'b0;
        st_wid_q   <= '0;
        st_addr_q  <= '0;
        irq_q      <= 1'b0;
      end
      if (viol_i && (!st_pend_q || clr)) begin
        st_pend_q  <= 1'b1;
        st_write_q <= viol_write_i;
        st_wid_q   <= viol_wid_i;
        st_addr_q  <= viol_addr_i;
      end
      if (viol_i && viol_irq_i) irq_q <= 1'b1;
    end
  end

  assign slots_o = slot_q;
  assign irq_o   = irq_q;

  // R10
  untrusted_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && cfg_write_i && cfg_wid_i != TRUSTED_WID) |=> cfg_rsp_err_o);

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(viol_i && viol_irq_i));
endmodule

// File: rtl/wid_access_checker.sv
module wid_access_checker
  import wac_pkg::*;
#(
  parameter int         NUM_SLOTS   = 4,
  parameter int         DATA_W      = 32,
  parameter int         CFG_AW      = 8,
  parameter logic [4:0] TRUSTED_WID = 5'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [63:0]       req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [4:0]        req_wid_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              tgt_valid_o,
  output logic              tgt_write_o,
  output logic [63:0]       tgt_addr_o,
  output logic [DATA_W-1:0] tgt_wdata_o,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_write_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [4:0]        cfg_wid_i,
  output logic              cfg_rsp_valid_o,
  output logic              cfg_rsp_err_o,
  output logic [31:0]       cfg_rdata_o,
  output logic              irq_o
);
  slot_t [NUM_SLOTS-1:0] slots;
  logic allow, deny_err, deny_irq, viol;
  logic rsp_valid_q, rsp_err_q, fwd_q, write_q;
  logic [63:0]       addr_q;
  logic [DATA_W-1:0] wdata_q;

  wac_decide #(.NUM_SLOTS(NUM_SLOTS)) u_decide (
    .slots_i (slots),
    .valid_i (req_valid_i),
    .addr_i  (req_addr_i),
    .wid_i   (req_wid_i),
    .write_i (req_write_i),
    .allow_o (allow),
    .err_o   (deny_err),
    .irq_o   (deny_irq)
  );

  assign viol = req_valid_i && !allow;

  wac_regs #(
    .NUM_SLOTS   (NUM_SLOTS),
    .CFG_AW      (CFG_AW),
    .TRUSTED_WID (TRUSTED_WID)
  ) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_valid_i     (cfg_valid_i),
    .cfg_write_i     (cfg_write_i),
    .cfg_addr_i      (cfg_addr_i),
    .cfg_wdata_i     (cfg_wdata_i),
    .cfg_wid_i       (cfg_wid_i),
    .cfg_rsp_valid_o (cfg_rsp_valid_o),
    .cfg_rsp_err_o   (cfg_rsp_err_o),
    .cfg_rdata_o     (cfg_rdata_o),
    .viol_i          (viol),
    .viol_irq_i      (deny_irq),
    .viol_write_i    (req_write_i),
    .viol_addr_i     (req_addr_i),
    .viol_wid_i      (req_wid_i),
    .slots_o         (slots),
    .irq_o           (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      fwd_q       <= 1'b0;
      write_q     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= viol && deny_err;
      fwd_q       <= req_valid_i && allow;
      if (req_valid_i) begin
        write_q <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = (fwd_q && !write_q) ? tgt_rdata_i : '0;
  assign tgt_valid_o = fwd_q;
  assign tgt_write_o = write_q;
  assign tgt_addr_o  = addr_q;
  assign tgt_wdata_o = wdata_q;

  // R5
  no_fwd_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tgt_valid_o && rsp_err_o));

  // R5
  blocked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !tgt_valid_o) |-> (rsp_rdata_o == '0));

  // R4
  fwd_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> $past(req_valid_i));
endmodule

// File: tb/wid_access_checker_tb.sv
module wid_access_checker_tb;
  localparam logic [4:0] TW = 5'd3;
  localparam int ST = 32;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [63:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [4:0]  req_wid = 0;
  logic        rsp_valid, rsp_err, tgt_valid, tgt_write;
  logic [31:0] rsp_rdata, tgt_wdata, tgt_rdata;
  logic [63:0] tgt_addr;
  logic        cfg_valid = 0, cfg_write = 0;
  logic [7:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [4:0]  cfg_wid = 0;
  logic        cfg_rsp_valid, cfg_rsp_err, irq;
  logic [31:0] cfg_rdata;

  assign tgt_rdata = tgt_addr[31:0] ^ 32'h5A5A_0000;

  wid_access_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_wid_i(req_wid),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .tgt_valid_o(tgt_valid), .tgt_write_o(tgt_write), .tgt_addr_o(tgt_addr),
    .tgt_wdata_o(tgt_wdata), .tgt_rdata_i(tgt_rdata),
    .cfg_valid_i(cfg_valid), .cfg_write_i(cfg_write), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_wid_i(cfg_wid),
    .cfg_rsp_valid_o(cfg_rsp_valid), .cfg_rsp_err_o(cfg_rsp_err),
    .cfg_rdata_o(cfg_rdata), .irq_o(irq)
  );

  int checks = 0, fails = 0;

  typedef struct {
    logic        fwd, err, wr;
    logic [31:0] rdata, wdata;
    logic [63:0] addr;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [63:0] a, input logic [4:0] w,
                      input logic fwd, input logic err, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wid = w;
    req_wdata = a[31:0] ^ 32'h0000_C0DE;
    e.fwd = fwd; e.err = err; e.wr = wr; e.addr = a; e.tag = tag;
    e.wdata = req_wdata;
    e.rdata = (fwd && !wr) ? (a[31:0] ^ 32'h5A5A_0000) : 32'h0;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(0, "R4 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_err == e.err, {e.tag, " err"}, rsp_err, e.err);
        chk(tgt_valid == e.fwd, {e.tag, " fwd"}, tgt_valid, e.fwd);
        chk(rsp_rdata == e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
        if (e.fwd)
          chk(tgt_addr == e.addr && tgt_write == e.wr && (!e.wr || tgt_wdata == e.wdata),
              {e.tag, " target fields"}, tgt_addr, e.addr);
      end
    end
  end

  task automatic cfg_op(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [4:0] w, output logic err, output logic [31:0] rd);
    @(negedge clk);
    cfg_valid = 1; cfg_write = wr; cfg_addr = a; cfg_wdata = d; cfg_wid = w;
    @(negedge clk);
    cfg_valid = 0;
    err = cfg_rsp_err; rd = cfg_rdata;
    chk(cfg_rsp_valid == 1, "R12 cfg response", cfg_rsp_valid, 1);
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    logic e; logic [31:0] r;
    cfg_op(1, a, d, TW, e, r);
    chk(e == 0, "R12 trusted write accepted", e, 0);
  endtask

  task automatic cfg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic e; logic [31:0] r;
    cfg_op(0, a, 0, 5'd1, e, r);
    chk(e == 0 && r == exp, tag, r, exp);
  endtask

  task automatic clear_status();
    cfg_wr(ST, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic e; logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(rsp_valid == 0 && tgt_valid == 0, "R1 no traffic after reset", {rsp_valid, tgt_valid}, 0);
    xfer(0, 64'h1000, 5'd0, 0, 1, "R1 R8 unconfigured access denied");
    idle();
    chk(irq == 0, "R8 no irq on unmatched address", irq, 0);
    cfg_rd(ST, 32'h1, "R9 capture after unmatched read");
    cfg_rd(ST + 1, 32'h1000, "R9 captured address");
    clear_status();
    cfg_rd(ST, 32'h0, "R9 status cleared");

    // R10 untrusted write
    cfg_op(1, 8'd0, 32'h1000, 5'd1, e, r);
    chk(e == 1, "R10 untrusted write error", e, 1);
    cfg_rd(8'd0, 32'h0, "R10 untrusted write ignored");

    // slot 0: 0x1000..0x1FFF, WID0/WID3 RW, WID17 write only, all reporting
    cfg_wr(8'd0, 32'h1000); cfg_wr(8'd1, 32'h0);
    cfg_wr(8'd2, 32'h1000); cfg_wr(8'd3, 32'h0);
    cfg_wr(8'd4, 32'hC3);   cfg_wr(8'd5, 32'h8);
    cfg_wr(8'd6, 32'hFFFF_FFEF);
    cfg_rd(8'd6, 32'h0F, "R11 reserved control bits read zero");
    cfg_rd(8'd4, 32'hC3, "R12 permission low readback");

    xfer(0, 64'h1000, 5'd0, 1, 0, "R4 allowed read at base");
    xfer(1, 64'h1FFC, 5'd3, 1, 0, "R4 allowed write at last word");
    xfer(0, 64'h2000, 5'd0, 0, 1, "R2 end address excluded");
    xfer(0, 64'h0FFF, 5'd0, 0, 1, "R2 below base excluded");
    idle();
    cfg_rd(ST, 32'h1, "R9 first violation kept");
    cfg_rd(ST + 1, 32'h2000, "R9 first address kept");
    clear_status();

    xfer(0, 64'h1010, 5'd1, 0, 1, "R5 denied read with error");
    idle();
    chk(irq == 1, "R6 read violation irq", irq, 1);
    xfer(1, 64'h1004, 5'd17, 1, 0, "R3 high word write grant");
    xfer(0, 64'h1004, 5'd17, 0, 1, "R3 high word read denied");
    idle();
    cfg_rd(ST, 32'h101, "R9 status wid and direction");
    cfg_rd(ST + 1, 32'h1010, "R9 address not overwritten");
    clear_status();
    chk(irq == 0, "R9 irq cleared", irq, 0);
    cfg_rd(ST, 32'h0, "R9 status cleared again");

    // slot 1: 0x0..0xFFFF, everything allowed, silent
    cfg_wr(8'd8, 32'h0); cfg_wr(8'd10, 32'h10000);
    cfg_wr(8'd12, 32'hFFFF_FFFF); cfg_wr(8'd13, 32'hFFFF_FFFF);
    xfer(0, 64'h1010, 5'd1, 0, 1, "R7 slot0 wins overlap");
    xfer(0, 64'h3000, 5'd1, 1, 0, "R7 slot1 alone allows");
    idle();
    chk(irq == 1, "R6 irq from slot0 deny", irq, 1);
    clear_status();

    // slot 2: 0x20000..0x200FF, no grants, write irq only
    cfg_wr(8'd16, 32'h20000); cfg_wr(8'd18, 32'h100); cfg_wr(8'd22, 32'h8);
    xfer(0, 64'h20010, 5'd0, 0, 0, "R5 denied read completes OKAY");
    idle();
    chk(irq == 0, "R6 read deny without read irq enable", irq, 0);
    xfer(1, 64'h20010, 5'd0, 0, 0, "R5 denied write completes OKAY");
    idle();
    chk(irq == 1, "R6 write irq enable", irq, 1);
    clear_status();
    chk(irq == 0, "R9 clear drops irq", irq, 0);

    // R11 lock
    cfg_wr(8'd22, 32'h18);
    cfg_op(1, 8'd18, 32'h200, TW, e, r);
    chk(e == 1, "R11 locked write error", e, 1);
    cfg_rd(8'd18, 32'h100, "R11 locked size unchanged");
    cfg_op(1, 8'd22, 32'h0, TW, e, r);
    chk(e == 1, "R11 locked control write error", e, 1);
    cfg_rd(8'd22, 32'h18, "R11 lock kept");

    // slot 3 above 4 GiB, WID2 read only, write errors reported
    cfg_wr(8'd24, 32'h0); cfg_wr(8'd25, 32'h1); cfg_wr(8'd26, 32'h10);
    cfg_wr(8'd28, 32'h10); cfg_wr(8'd30, 32'h2);
    xfer(0, 64'h1_0000_0008, 5'd2, 1, 0, "R2 upper address word match");
    xfer(1, 64'h1_0000_0008, 5'd2, 0, 1, "R3 WID2 write bit clear");
    xfer(0, 64'h1_0000_0010, 5'd2, 0, 1, "R2 R8 past upper region");
    idle();
    @(negedge clk);
    chk(q.size() == 0, "R4 all responses seen", q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule